// File: doc/BRIEF.md
# CCD Frame Sequencer with Electronic Shutter

The sequencer drives an area CCD through one frame. A frame has four phases in a fixed order: an integration interval, a photodiode-to-vertical-register transfer, line-by-line readout, and a closing timed-integration interval. Each readout line first clocks the vertical registers and then opens a horizontal readout window. During that window the sequencer raises the line-valid and horizontal-clock-enable outputs. Frame-valid covers the whole readout, from the start of the first line to the end of the last.

An electronic shutter sequence can be spliced into the frame. It has a programmable setup interval, a pulse of programmable width and a programmable hold interval. It runs ahead of a chosen line, and that line becomes longer by exactly the length of the sequence. The shutter is placed in one of two ways. A programmed line number can select the line, where zero means "directly after the diode transfer". A force flag can instead put it ahead of the first line. A line number beyond the frame's last line turns the shutter off.

A binning mode clocks the vertical registers twice per line instead of once, which sums two rows into the horizontal register. All settings are captured when a frame starts. A line count of zero selects a default count that depends on the mode.

Top module: `ccd_frame_seq`

## Requirements
- R1: After reset, `phase` is 0 (idle) and `v1`, `v2`, `h_en`, `shutter`, `frame_valid` and `line_valid` are all low.
- R2: A `frame_start` high at a clock edge while idle begins a frame. The frame runs INT_CYC cycles of phase 1 (integrate), DX_CYC cycles of phase 2 (diode transfer), then the readout lines, then TI_CYC cycles of phase 6 (timed integration), and then returns to phase 0. `h_en` is high in phases 1 and 6. A `frame_start` seen outside idle is ignored.
- R3: All configuration inputs are captured on the edge that starts a frame. Changing them during the frame has no effect on that frame.
- R4: Each line begins with phase 4 (vertical transfer). In it, `v1` is high for VPW cycles and then `v2` is high for VPW cycles. This happens once in normal mode (`bin_mode`=0) and twice in binning mode (`bin_mode`=1). Phase 5 (readout) then lasts `pix_per_line` cycles with `line_valid` and `h_en` high.
- R5: `frame_valid` is high from the first cycle of line 1 to the last readout cycle of the last line, including any shutter inside a line, and low at all other times. `line_valid` is high only in phase 5.
- R6: `h_en` is low whenever `v1`, `v2` or `shutter` is high. `v1` and `v2` are never high together.
- R7: A shutter sequence is phase 3. It holds `shutter` low for `sh_setup` cycles, high for `sh_width` cycles and low for `sh_hold` cycles. The line it precedes grows by their sum. If all three values are zero, nothing is inserted.
- R8: When `sh_line` is k, with 1 ≤ k ≤ line count, the shutter sequence runs at the start of line k, before that line's vertical transfer.
- R9: When `sh_line` is 0, the shutter sequence runs right after the diode transfer and before line 1, with `frame_valid` low.
- R10: When `sh_line` is greater than the line count and the force flag is clear, the frame has no shutter sequence.
- R11: When `force_sh` is set, the shutter runs ahead of line 1, or after the diode transfer if `sh_line` is 0. At most one shutter sequence occurs per frame, whichever triggers select it.
- R12: A `line_count` of 0 selects 1104 lines in normal mode and 610 lines in binning mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Starts a frame when idle |
| bin_mode | input | 1 | 1 = 2x2 binning, 0 = normal |
| line_count | input | 11 | Lines per frame, 0 = mode default |
| pix_per_line | input | 12 | Readout cycles per line (≥1) |
| sh_setup | input | 8 | Shutter setup cycles |
| sh_width | input | 8 | Shutter pulse cycles |
| sh_hold | input | 8 | Shutter hold cycles |
| sh_line | input | 11 | Line the shutter precedes (0 = after diode transfer) |
| force_sh | input | 1 | Force the shutter ahead of line 1 |
| v1 | output | 1 | Vertical clock phase 1 |
| v2 | output | 1 | Vertical clock phase 2 |
| h_en | output | 1 | Horizontal clock enable |
| shutter | output | 1 | Electronic shutter pulse |
| frame_valid | output | 1 | Readout in progress |
| line_valid | output | 1 | Pixel readout window |
| phase | output | 3 | Current phase code |

## Verification
In the same frame, both the programmed line number and the force flag can select a shutter. The one-shot rule then has to settle which single sequence appears. The bench provokes this with force set together with line numbers 0, 1, 3 and out-of-range values, in both directed frames and random frames. Each frame is judged cycle by cycle against a bench model. The model places exactly one stretched shutter segment, or none, and every line segment is compared for phase, clocks, enables and valids. A second overlap is a `frame_start` arriving mid-frame while the inputs are scrambled. The bench judges it by checking that the frame's timeline is unchanged.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;
    localparam int LINE_W = 11;
    localparam int PIX_W  = 12;
    localparam int SH_W   = 8;

    localparam logic [LINE_W-1:0] DEF_LINES_NORM = LINE_W'(1104);
    localparam logic [LINE_W-1:0] DEF_LINES_BIN  = LINE_W'(610);

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_INTEG = 3'd1,
        PH_DIODE = 3'd2,
        PH_SHUT  = 3'd3,
        PH_VXFER = 3'd4,
        PH_HREAD = 3'd5,
        PH_TIMED = 3'd6
    } phase_e;

    typedef struct packed {
        logic              bin;
        logic [LINE_W-1:0] lines;
        logic [PIX_W-1:0]  ppl;
        logic [SH_W-1:0]   setup;
        logic [SH_W-1:0]   width;
        logic [SH_W-1:0]   hold;
        logic [LINE_W-1:0] sh_line;
        logic              force_sh;
    } frame_cfg_t;
endpackage

// File: rtl/ccd_shutter_gen.sv
module ccd_shutter_gen #(
    parameter int SW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [SW-1:0] setup,
    input  logic [SW-1:0] width,
    input  logic [SW-1:0] hold,
    output logic          pulse,
    output logic          last
);
    localparam int TW = SW + 2;

    logic [TW-1:0] total;
    logic [TW-1:0] pulse_end;
    logic [TW-1:0] t_d, t_q;
    logic          act_d, act_q;

    always_comb begin
        total     = TW'(setup) + TW'(width) + TW'(hold);
        pulse_end = TW'(setup) + TW'(width);
        t_d       = t_q;
        act_d     = act_q;
        if (start) begin
            t_d   = '0;
            act_d = 1'b1;
        end else if (act_q) begin
            if (t_q == total - TW'(1)) act_d = 1'b0;
            else                       t_d   = t_q + TW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q   <= '0;
            act_q <= 1'b0;
        end else begin
            t_q   <= t_d;
            act_q <= act_d;
        end
    end

    assign pulse = act_q && (t_q >= TW'(setup)) && (t_q < pulse_end);
    assign last  = act_q && (t_q == total - TW'(1));

    // R7
    sh_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !act_q);
    // R7
    sh_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last && !start) |=> !pulse);
endmodule

// File: rtl/ccd_vclk_gen.sv
module ccd_vclk_gen #(
    parameter int VPW = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic twice,
    output logic v1,
    output logic v2,
    output logic last
);
    localparam int PER = 2 * VPW;
    localparam int TW  = $clog2(2 * PER + 1);

    logic [TW-1:0] t_d, t_q;
    logic [TW-1:0] total;
    logic [TW-1:0] tb;
    logic          act_d, act_q;
    logic          two_d, two_q;

    always_comb begin
        total = two_q ? TW'(2 * PER) : TW'(PER);
        t_d   = t_q;
        act_d = act_q;
        two_d = two_q;
        if (start) begin
            t_d   = '0;
            act_d = 1'b1;
            two_d = twice;
        end else if (act_q) begin
            if (t_q == total - TW'(1)) act_d = 1'b0;
            else                       t_d   = t_q + TW'(1);
        end
        tb = (t_q >= TW'(PER)) ? t_q - TW'(PER) : t_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q   <= '0;
            act_q <= 1'b0;
            two_q <= 1'b0;
        end else begin
            t_q   <= t_d;
            act_q <= act_d;
            two_q <= two_d;
        end
    end

    assign v1   = act_q && (tb <  TW'(VPW));
    assign v2   = act_q && (tb >= TW'(VPW));
    assign last = act_q && (t_q == total - TW'(1));

    // R4
    v_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(v1) && act_q) |-> v2);
endmodule

// File: rtl/ccd_frame_seq.sv
module ccd_frame_seq
    import ccd_seq_pkg::*;
#(
    parameter int INT_CYC = 8,
    parameter int DX_CYC  = 4,
    parameter int TI_CYC  = 6,
    parameter int VPW     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              bin_mode,
    input  logic [LINE_W-1:0] line_count,
    input  logic [PIX_W-1:0]  pix_per_line,
    input  logic [SH_W-1:0]   sh_setup,
    input  logic [SH_W-1:0]   sh_width,
    input  logic [SH_W-1:0]   sh_hold,
    input  logic [LINE_W-1:0] sh_line,
    input  logic              force_sh,
    output logic              v1,
    output logic              v2,
    output logic              h_en,
    output logic              shutter,
    output logic              frame_valid,
    output logic              line_valid,
    output logic [2:0]        phase
);
    localparam int CW = PIX_W;

    typedef struct packed {
        phase_e            phase;
        logic [CW-1:0]     cnt;
        logic [LINE_W-1:0] line;
        logic              sh_done;
        frame_cfg_t        cfg;
    } seq_state_t;

    seq_state_t s_d, s_q;
    logic sh_start, v_start;
    logic sh_last, v_last;
    logic sh_nonzero, pre_hit, line_hit;
    logic [LINE_W-1:0] next_line;

    ccd_shutter_gen #(.SW(SH_W)) u_shut (
        .clk   (clk),
        .rst_n (rst_n),
        .start (sh_start),
        .setup (s_q.cfg.setup),
        .width (s_q.cfg.width),
        .hold  (s_q.cfg.hold),
        .pulse (shutter),
        .last  (sh_last)
    );

    ccd_vclk_gen #(.VPW(VPW)) u_vclk (
        .clk   (clk),
        .rst_n (rst_n),
        .start (v_start),
        .twice (s_q.cfg.bin),
        .v1    (v1),
        .v2    (v2),
        .last  (v_last)
    );

    always_comb begin
        s_d        = s_q;
        sh_start   = 1'b0;
        v_start    = 1'b0;
        next_line  = s_q.line + LINE_W'(1);
        sh_nonzero = |{s_q.cfg.setup, s_q.cfg.width, s_q.cfg.hold};
        pre_hit    = !s_q.sh_done && sh_nonzero && (s_q.cfg.sh_line == '0);
        line_hit   = !s_q.sh_done && sh_nonzero &&
                     ((s_q.cfg.sh_line == next_line) ||
                      (s_q.cfg.force_sh && (next_line == LINE_W'(1))));

        unique case (s_q.phase)
            PH_IDLE: begin
                if (frame_start) begin
                    s_d.phase            = PH_INTEG;
                    s_d.cnt              = '0;
                    s_d.line             = '0;
                    s_d.sh_done          = 1'b0;
                    s_d.cfg.bin          = bin_mode;
                    s_d.cfg.lines        = (line_count != '0) ? line_count :
                                           (bin_mode ? DEF_LINES_BIN : DEF_LINES_NORM);
                    s_d.cfg.ppl          = pix_per_line;
                    s_d.cfg.setup        = sh_setup;
                    s_d.cfg.width        = sh_width;
                    s_d.cfg.hold         = sh_hold;
                    s_d.cfg.sh_line      = sh_line;
                    s_d.cfg.force_sh     = force_sh;
                end
            end
            PH_INTEG: begin
                if (s_q.cnt == CW'(INT_CYC - 1)) begin
                    s_d.phase = PH_DIODE;
                    s_d.cnt   = '0;
                end else begin
                    s_d.cnt = s_q.cnt + CW'(1);
                end
            end
            PH_DIODE: begin
                if (s_q.cnt == CW'(DX_CYC - 1)) begin
                    s_d.cnt = '0;
                    if (pre_hit) begin
                        s_d.phase   = PH_SHUT;
                        s_d.sh_done = 1'b1;
                        sh_start    = 1'b1;
                    end else begin
                        s_d.line = next_line;
                        if (line_hit) begin
                            s_d.phase   = PH_SHUT;
                            s_d.sh_done = 1'b1;
                            sh_start    = 1'b1;
                        end else begin
                            s_d.phase = PH_VXFER;
                            v_start   = 1'b1;
                        end
                    end
                end else begin
                    s_d.cnt = s_q.cnt + CW'(1);
                end
            end
            PH_SHUT: begin
                if (sh_last) begin
                    if (s_q.line == '0) s_d.line = LINE_W'(1);
                    s_d.phase = PH_VXFER;
                    v_start   = 1'b1;
                end
            end
            PH_VXFER: begin
                if (v_last) begin
                    s_d.phase = PH_HREAD;
                    s_d.cnt   = '0;
                end
            end
            PH_HREAD: begin
                if (s_q.cnt == s_q.cfg.ppl - CW'(1)) begin
                    s_d.cnt = '0;
                    if (s_q.line == s_q.cfg.lines) begin
                        s_d.phase = PH_TIMED;
                    end else begin
                        s_d.line = next_line;
                        if (line_hit) begin
                            s_d.phase   = PH_SHUT;
                            s_d.sh_done = 1'b1;
                            sh_start    = 1'b1;
                        end else begin
                            s_d.phase = PH_VXFER;
                            v_start   = 1'b1;
                        end
                    end
                end else begin
                    s_d.cnt = s_q.cnt + CW'(1);
                end
            end
            PH_TIMED: begin
                if (s_q.cnt == CW'(TI_CYC - 1)) begin
                    s_d.phase = PH_IDLE;
                    s_d.cnt   = '0;
                end else begin
                    s_d.cnt = s_q.cnt + CW'(1);
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign phase       = s_q.phase;
    assign line_valid  = (s_q.phase == PH_HREAD);
    assign h_en        = (s_q.phase == PH_HREAD) || (s_q.phase == PH_INTEG) ||
                         (s_q.phase == PH_TIMED);
    assign frame_valid = (s_q.line != '0) &&
                         ((s_q.phase == PH_SHUT) || (s_q.phase == PH_VXFER) ||
                          (s_q.phase == PH_HREAD));

    // R5
    lv_in_fv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_valid |-> frame_valid);
    // R6
    hen_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (v1 || v2 || shutter) |-> !h_en);
    // R6
    v_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(v1 && v2));
    // R5
    fv_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_valid) |-> ((s_q.phase == PH_SHUT) || (s_q.phase == PH_VXFER)));
    // R2
    idle_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_IDLE) |=> ((s_q.phase == PH_IDLE) || (s_q.phase == PH_INTEG)));
    // R11
    one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sh_start |-> !s_q.sh_done);
endmodule

// File: tb/ccd_frame_seq_test.sv
`timescale 1ns/1ps
module ccd_frame_seq_test;
    localparam int INT_CYC = 8;
    localparam int DX_CYC  = 4;
    localparam int TI_CYC  = 6;
    localparam int VPW     = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0;
    logic        bin_mode = 1'b0;
    logic [10:0] line_count = '0;
    logic [11:0] pix_per_line = 12'd1;
    logic [7:0]  sh_setup = '0, sh_width = '0, sh_hold = '0;
    logic [10:0] sh_line = '0;
    logic        force_sh = 1'b0;
    logic        v1, v2, h_en, shutter, frame_valid, line_valid;
    logic [2:0]  phase;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ccd_frame_seq #(.INT_CYC(INT_CYC), .DX_CYC(DX_CYC), .TI_CYC(TI_CYC), .VPW(VPW)) uut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .bin_mode(bin_mode),
        .line_count(line_count), .pix_per_line(pix_per_line), .sh_setup(sh_setup),
        .sh_width(sh_width), .sh_hold(sh_hold), .sh_line(sh_line), .force_sh(force_sh),
        .v1(v1), .v2(v2), .h_en(h_en), .shutter(shutter), .frame_valid(frame_valid),
        .line_valid(line_valid), .phase(phase)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int obs();
        return {phase, v1, v2, h_en, shutter, frame_valid, line_valid};
    endfunction

    // kind: 0 plain, 1 shutter (a=setup, b=width), 2 vertical clocks, 3 readout
    task automatic seg(input int ph, input int n, input bit fv, input int kind,
                       input int a, input int b, input string req);
        int bad = 0;
        int fa = 0, fe = 0;
        for (int t = 0; t < n; t++) begin
            bit ev1 = 0, ev2 = 0, esh = 0, elv = 0, ehen;
            int e;
            ehen = (ph == 1) || (ph == 5) || (ph == 6);
            if (kind == 1) esh = (t >= a) && (t < a + b);
            if (kind == 2) begin
                ev1 = (t % (2 * VPW)) < VPW;
                ev2 = !ev1;
            end
            if (kind == 3) elv = 1;
            e = {3'(ph), ev1, ev2, ehen, esh, fv, elv};
            if (obs() != e && bad == 0) begin
                bad = 1; fa = obs(); fe = e;
            end
            @(negedge clk);
        end
        check(bad == 0, req, fa, fe);
    endtask

    function automatic int shutter_at(input int lines, input int su, input int wd,
                                      input int ho, input int sl, input bit frc);
        if (su + wd + ho == 0) return -1;
        if (sl == 0) return 0;
        if (frc) return 1;
        if (sl <= lines) return sl;
        return -1;
    endfunction

    task automatic run_frame(input bit bin, input int lc, input int ppl, input int su,
                             input int wd, input int ho, input int sl, input bit frc,
                             input bit poke);
        int lines, sat, tot;
        lines = (lc == 0) ? (bin ? 610 : 1104) : lc;
        sat = shutter_at(lines, su, wd, ho, sl, frc);
        tot = su + wd + ho;
        @(negedge clk);
        bin_mode = bin; line_count = 11'(lc); pix_per_line = 12'(ppl);
        sh_setup = 8'(su); sh_width = 8'(wd); sh_hold = 8'(ho);
        sh_line = 11'(sl); force_sh = frc; frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        if (poke) begin
            // R3: scramble inputs and re-pulse frame_start mid-frame
            frame_start = 1'b1;
            bin_mode = ~bin; line_count = 11'($urandom_range(1, 9));
            pix_per_line = 12'($urandom_range(1, 9)); sh_setup = 8'($urandom_range(0, 5));
            sh_width = 8'($urandom_range(0, 5)); sh_hold = 8'($urandom_range(0, 5));
            sh_line = 11'($urandom_range(0, 9)); force_sh = ~frc;
        end
        seg(1, 1, 0, 0, 0, 0, "R3");
        frame_start = 1'b0;
        seg(1, INT_CYC - 1, 0, 0, 0, 0, "R2");
        seg(2, DX_CYC, 0, 0, 0, 0, "R2");
        if (sat == 0) seg(3, tot, 0, 1, su, wd, "R9");
        for (int k = 1; k <= lines; k++) begin
            if (sat == k) seg(3, tot, 1, 1, su, wd, frc ? "R11" : "R8");
            seg(4, bin ? 4 * VPW : 2 * VPW, 1, 2, 0, 0, "R4");
            seg(5, ppl, 1, 3, 0, 0, lc == 0 ? "R12" : "R5");
        end
        seg(6, TI_CYC, 0, 0, 0, 0, sat < 0 ? "R10" : "R7");
        seg(0, 1, 0, 0, 0, 0, "R2");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0001));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(obs() == 0, "R1", obs(), 0);
        run_frame(0, 3, 4, 1, 2, 1, 2, 0, 0);        // R8 shutter at line 2
        run_frame(1, 2, 3, 2, 1, 2, 0, 0, 1);        // R9 after diode, R3 poke
        run_frame(0, 3, 2, 1, 1, 1, 9, 0, 0);        // R10 out of range
        run_frame(0, 3, 2, 0, 2, 0, 3, 1, 0);        // R11 force wins, one pulse
        run_frame(1, 2, 2, 1, 1, 0, 0, 1, 0);        // R11 force with line 0
        run_frame(0, 2, 2, 0, 0, 0, 1, 1, 0);        // R7 zero length
        run_frame(0, 2, 3, 3, 0, 2, 1, 0, 0);        // R7 zero width
        run_frame(1, 0, 1, 1, 1, 1, 610, 0, 0);      // R12 binning default
        run_frame(0, 0, 1, 0, 1, 0, 2000, 0, 0);     // R12 normal default
        for (int i = 0; i < 24; i++) begin
            run_frame(1'($urandom_range(0, 1)), $urandom_range(1, 6), $urandom_range(1, 6),
                      $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3),
                      $urandom_range(0, 8), 1'($urandom_range(0, 1)),
                      1'($urandom_range(0, 1)));
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule